// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the memory from power-on to a usable state. Once reset is released it keeps clock enable and the data mask high and drives a no-operation command for a programmable settling time. It then closes every bank with one precharge. Next come a programmable number of auto refreshes and a single mode register load, in an order chosen at build time. Each command is followed by the spacing time the memory needs before the next one.

When the last spacing time has run out, the block raises a ready flag and releases the data mask. From then on the command bus stays idle. A one-cycle refresh-due pulse is produced at a fixed interval, which a higher-level arbiter uses to schedule periodic refreshes. All timing values are parameters counted in clock cycles. The defaults suit a 50 MHz clock: a 200 µs settling time and a 15.6 µs refresh interval.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is low, and in the cycle after it is released, clock enable is high, every data-mask bit is high, the command is NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), address and bank are zero, and the ready and refresh-due outputs are low.
- R2: The bus shows NOP until the WAIT_CYC-th rising edge after reset release. That edge drives precharge-all: command 0,0,1,0 with address bit AP_BIT high, all other address bits zero and bank zero.
- R3: The first command after precharge-all appears exactly TRP_CYC edges later. No refresh or mode load appears before then.
- R4: Exactly REF_CNT auto refreshes (command 0,0,0,1, address and bank zero) are issued. Consecutive refreshes are exactly TRC_CYC edges apart.
- R5: The mode load (command 0,0,0,0) drives MODE_WORD onto {bank, address}, with the bank pins as the upper bits.
- R6: With MRS_FIRST=0, the refreshes follow precharge-all and the mode load comes TRC_CYC edges after the last refresh. With MRS_FIRST=1, the mode load comes first and the first refresh follows it by TMRD_CYC edges.
- R7: Ready rises TMRD_CYC edges after a final mode load, or TRC_CYC edges after a final refresh, and then stays high. The data mask goes low on the same edge and stays high before it.
- R8: Each command lasts one cycle and NOP fills every other cycle, including all cycles after ready. Clock enable never drops.
- R9: After ready, refresh_due is a one-cycle pulse. The first pulse comes REFI_CYC edges after ready rises, and later pulses follow every REFI_CYC edges.
- R10: Asserting reset at any point returns all outputs to the R1 state at once. On release the whole sequence restarts from the settling wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_dqm | output | DQM_W | Data mask, one bit per byte lane |
| sdr_addr | output | ADDR_W | Multiplexed address |
| sdr_ba | output | BANK_W | Bank select |
| init_done | output | 1 | Initialisation complete |
| refresh_due | output | 1 | Periodic refresh request pulse |

## Verification
Every output is registered, so the result of each step shows up on the exact rising edge that the requirements name: edge WAIT_CYC for precharge-all, and the accumulated sums of TRP_CYC, TRC_CYC and TMRD_CYC for the later commands, ready and the refresh pulses. The bench counts rising edges since reset release and builds the expected command schedule from the requirement arithmetic. It then samples all outputs on the falling edge after each rising edge, so each comparison sees the value that edge produced. Two instances cover the two step orders. Reset is also applied mid-sequence; it is checked right after assertion and the edge count restarts from zero.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int ADDR_W    = 11,
  parameter int BANK_W    = 2,
  parameter int DQM_W     = 4,
  parameter int AP_BIT    = 10,
  parameter int WAIT_CYC  = 10000,
  parameter int TRP_CYC   = 3,
  parameter int TRC_CYC   = 10,
  parameter int TMRD_CYC  = 2,
  parameter int REF_CNT   = 2,
  parameter int MRS_FIRST = 0,
  parameter int REFI_CYC  = 780,
  parameter logic [ADDR_W+BANK_W-1:0] MODE_WORD = 'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sdr_cke,
  output logic              sdr_cs_n,
  output logic              sdr_ras_n,
  output logic              sdr_cas_n,
  output logic              sdr_we_n,
  output logic [DQM_W-1:0]  sdr_dqm,
  output logic [ADDR_W-1:0] sdr_addr,
  output logic [BANK_W-1:0] sdr_ba,
  output logic              init_done,
  output logic              refresh_due
);

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int STEP_MAX = max_of(max_of(WAIT_CYC, TRP_CYC), max_of(TRC_CYC, TMRD_CYC));
  localparam int CNT_W    = $clog2(STEP_MAX + 1);
  localparam int RC_W     = $clog2(REF_CNT + 1);
  localparam int RI_W     = $clog2(REFI_CYC + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef enum logic [2:0] {ST_PRE, ST_REF, ST_MRS, ST_RDY, ST_RUN} st_t;

  localparam st_t AFTER_PRE  = (MRS_FIRST != 0) ? ST_MRS : ST_REF;
  localparam st_t AFTER_REFS = (MRS_FIRST != 0) ? ST_RDY : ST_MRS;
  localparam st_t AFTER_MRS  = (MRS_FIRST != 0) ? ST_REF : ST_RDY;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [RC_W-1:0]  refs_left;
  logic [RI_W-1:0]  ri_cnt;
  logic [3:0]       cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] ba_q;

  assign {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = cmd_q;
  assign sdr_cke  = 1'b1;
  assign sdr_dqm  = {DQM_W{~init_done}};
  assign sdr_addr = addr_q;
  assign sdr_ba   = ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_PRE;
      cnt         <= CNT_W'(WAIT_CYC - 1);
      refs_left   <= RC_W'(REF_CNT);
      ri_cnt      <= '0;
      cmd_q       <= C_NOP;
      addr_q      <= '0;
      ba_q        <= '0;
      init_done   <= 1'b0;
      refresh_due <= 1'b0;
    end else begin
      cmd_q       <= C_NOP;
      addr_q      <= '0;
      ba_q        <= '0;
      refresh_due <= 1'b0;
      if (st == ST_RUN) begin
        if (ri_cnt == '0) begin
          refresh_due <= 1'b1;
          ri_cnt      <= RI_W'(REFI_CYC - 1);
        end else begin
          ri_cnt <= ri_cnt - 1'b1;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          ST_PRE: begin
            cmd_q          <= C_PRE;
            addr_q[AP_BIT] <= 1'b1;
            cnt            <= CNT_W'(TRP_CYC - 1);
            st             <= AFTER_PRE;
          end
          ST_REF: begin
            cmd_q     <= C_REF;
            cnt       <= CNT_W'(TRC_CYC - 1);
            refs_left <= refs_left - 1'b1;
            if (refs_left == RC_W'(1)) st <= AFTER_REFS;
          end
          ST_MRS: begin
            cmd_q          <= C_MRS;
            {ba_q, addr_q} <= MODE_WORD;
            cnt            <= CNT_W'(TMRD_CYC - 1);
            st             <= AFTER_MRS;
          end
          ST_RDY: begin
            init_done <= 1'b1;
            ri_cnt    <= RI_W'(REFI_CYC - 1);
            st        <= ST_RUN;
          end
          default: st <= ST_RUN;
        endcase
      end
    end
  end

endmodule

module sdram_powerup_seq_chk #(
  parameter int DQM_W   = 4,
  parameter int TRP_CYC = 3,
  parameter int TRC_CYC = 10,
  parameter int REF_CNT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             ap,
  input logic [DQM_W-1:0] dqm,
  input logic             ready,
  input logic             due
);
  localparam logic [3:0] K_NOP = 4'b0111;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_REF = 4'b0001;
  localparam logic [3:0] K_MRS = 4'b0000;

  logic [3:0]  cmd_w;
  logic [3:0]  last_cmd;
  logic [15:0] since_cmd;
  logic [15:0] since_pre;
  logic        pre_seen;
  logic        mrs_seen;
  logic [15:0] ref_seen;

  assign cmd_w = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd  <= K_NOP;
      since_cmd <= '0;
      since_pre <= '0;
      pre_seen  <= 1'b0;
      mrs_seen  <= 1'b0;
      ref_seen  <= '0;
    end else begin
      if (cmd_w != K_NOP) begin
        last_cmd  <= cmd_w;
        since_cmd <= 16'd1;
      end else if (since_cmd != 16'hFFFF) begin
        since_cmd <= since_cmd + 16'd1;
      end
      if (cmd_w == K_PRE) begin
        pre_seen  <= 1'b1;
        since_pre <= 16'd1;
      end else if (since_pre != 16'hFFFF) begin
        since_pre <= since_pre + 16'd1;
      end
      if (cmd_w == K_MRS) mrs_seen <= 1'b1;
      if (cmd_w == K_REF && ref_seen != 16'hFFFF) ref_seen <= ref_seen + 16'd1;
    end
  end

  // R8
  cmd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w != K_NOP) |=> (cmd_w == K_NOP));

  // R8
  idle_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd_w == K_NOP));

  // R2
  pre_all_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == K_PRE) |-> ap);

  // R3
  after_pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == K_REF || cmd_w == K_MRS) |-> (pre_seen && since_pre >= 16'(TRP_CYC)));

  // R4
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w != K_NOP && last_cmd == K_REF) |-> (since_cmd >= 16'(TRC_CYC)));

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R7
  ready_after_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (mrs_seen && ref_seen >= 16'(REF_CNT)));

  // R7
  mask_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (&dqm));

  // R9
  due_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due |-> ready);

  // R9
  due_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> !due);
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .DQM_W(DQM_W), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .REF_CNT(REF_CNT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(sdr_cs_n), .ras_n(sdr_ras_n), .cas_n(sdr_cas_n),
  .we_n(sdr_we_n), .ap(sdr_addr[AP_BIT]), .dqm(sdr_dqm), .ready(init_done), .due(refresh_due)
);

// File: tb/sdram_powerup_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_powerup_seq_tb_top;
  localparam int W = 40;
  localparam int TRP = 3;
  localparam int REFI = 25;
  localparam int TRC_A = 7;
  localparam int TRC_B = 10;
  localparam int NREF_A = 3;
  localparam int NREF_B = 2;
  localparam logic [12:0] MODE_A = 13'h0032;
  localparam logic [12:0] MODE_B = 13'h0223;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_rdy, a_due;
  logic [3:0] a_dqm; logic [10:0] a_addr; logic [1:0] a_ba;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_rdy, b_due;
  logic [3:0] b_dqm; logic [10:0] b_addr; logic [1:0] b_ba;

  sdram_powerup_seq #(.WAIT_CYC(W), .TRP_CYC(TRP), .TRC_CYC(TRC_A), .TMRD_CYC(2),
    .REF_CNT(NREF_A), .MRS_FIRST(0), .REFI_CYC(REFI), .MODE_WORD(MODE_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .sdr_cke(a_cke), .sdr_cs_n(a_cs), .sdr_ras_n(a_ras),
    .sdr_cas_n(a_cas), .sdr_we_n(a_we), .sdr_dqm(a_dqm), .sdr_addr(a_addr), .sdr_ba(a_ba),
    .init_done(a_rdy), .refresh_due(a_due));

  sdram_powerup_seq #(.WAIT_CYC(W), .TRP_CYC(TRP), .TRC_CYC(TRC_B), .TMRD_CYC(2),
    .REF_CNT(NREF_B), .MRS_FIRST(1), .REFI_CYC(REFI), .MODE_WORD(MODE_B)) dut_b (
    .clk(clk), .rst_n(rst_n), .sdr_cke(b_cke), .sdr_cs_n(b_cs), .sdr_ras_n(b_ras),
    .sdr_cas_n(b_cas), .sdr_we_n(b_we), .sdr_dqm(b_dqm), .sdr_addr(b_addr), .sdr_ba(b_ba),
    .init_done(b_rdy), .refresh_due(b_due));

  int checks = 0;
  int errors = 0;
  int k = 0;
  string pfx = "";

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s%s at edge %0d: actual %h expected %h", pfx, tag, k, act, exp);
    end
  endtask

  function automatic void model(input int kk, input int trc, input int nref, input int mf,
      input logic [12:0] mode, output logic [3:0] cmd, output logic [10:0] a,
      output logic [1:0] b, output logic rdy, output logic due);
    int ev[$];
    logic [3:0] ec[$];
    int t;
    cmd = NOP; a = '0; b = '0;
    t = W; ev.push_back(t); ec.push_back(PRE); t += TRP;
    if (mf != 0) begin ev.push_back(t); ec.push_back(MRS); t += 2; end
    for (int i = 0; i < nref; i++) begin ev.push_back(t); ec.push_back(REF); t += trc; end
    if (mf == 0) begin ev.push_back(t); ec.push_back(MRS); t += 2; end
    for (int i = 0; i < ev.size(); i++) if (ev[i] == kk) cmd = ec[i];
    if (cmd == PRE) a = 11'h400;
    if (cmd == MRS) {b, a} = mode;
    rdy = (kk >= t);
    due = rdy && (kk > t) && (((kk - t) % REFI) == 0);
  endfunction

  task automatic check_reset_state(input string tag);
    cmp({tag, " A reset"}, {a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_addr, a_ba, a_rdy, a_due},
        {1'b1, 4'hF, NOP, 11'h0, 2'b0, 1'b0, 1'b0});
    cmp({tag, " B reset"}, {b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_addr, b_ba, b_rdy, b_due},
        {1'b1, 4'hF, NOP, 11'h0, 2'b0, 1'b0, 1'b0});
  endtask

  task automatic compare_all();
    logic [3:0] ec; logic [10:0] ea; logic [1:0] eb; logic er, ed;
    model(k, TRC_A, NREF_A, 0, MODE_A, ec, ea, eb, er, ed);
    cmp("R2 R3 R4 R5 R6 R8 A command", {a_cs, a_ras, a_cas, a_we}, ec);
    cmp("R2 R5 A address/bank", {a_ba, a_addr}, {eb, ea});
    cmp("R7 A ready", a_rdy, er);
    cmp("R7 A dqm", a_dqm, er ? 4'h0 : 4'hF);
    cmp("R9 A refresh_due", a_due, ed);
    cmp("R8 A cke", a_cke, 1'b1);
    model(k, TRC_B, NREF_B, 1, MODE_B, ec, ea, eb, er, ed);
    cmp("R2 R3 R4 R5 R6 R8 B command", {b_cs, b_ras, b_cas, b_we}, ec);
    cmp("R2 R5 B address/bank", {b_ba, b_addr}, {eb, ea});
    cmp("R7 B ready", b_rdy, er);
    cmp("R7 B dqm", b_dqm, er ? 4'h0 : 4'hF);
    cmp("R9 B refresh_due", b_due, ed);
    cmp("R8 B cke", b_cke, 1'b1);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    k = 0;
    #1 check_reset_state("R1 released");
    run(W + 30 + 4 * REFI);

    @(negedge clk); rst_n = 1'b0;
    #1 check_reset_state("R10 late");
    @(negedge clk); rst_n = 1'b1; k = 0;
    pfx = "R10 restart ";
    run(W + TRP + 3);

    @(negedge clk); rst_n = 1'b0;
    #1 check_reset_state("R10 mid");
    repeat (2) @(negedge clk);
    rst_n = 1'b1; k = 0;
    run(W + 30 + 3 * REFI);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired at edge %0d", k);
    summary();
    $finish;
  end
endmodule